// File: doc/BRIEF.md
# Legacy Interrupt Virtual Wire Merger

This block sits at the upstream side of a switch or bridge and folds the level-style legacy interrupt messages from several downstream ports into four shared virtual wires, A to D. Each downstream port holds its own four level bits. A message sets or clears one of those bits. Before the merge, a port's wires are rotated by the port number, so devices that all signal on wire A are spread over the four shared outputs.

The four merged levels are the OR of the rotated port levels. The block remembers the last level it reported upstream for each shared wire. It sends an assert or deassert message only when a merged level moves away from that reported value. When several wires differ at the same time, or the upstream side stalls, the block sends them one per handshake, lowest wire first. A change that reverts before it is sent is never reported. A link-down input per port clears that port's levels, and the resulting drops are reported like any other.

Top module: `intx_vw_merge`

## Requirements
- R1: Synchronous active-high reset clears every port level and every reported level, and holds `out_valid` low. After reset, the first assert of any source is reported again.
- R2: On an input message, `in_wire` selects the wire (0=A, 1=B, 2=C, 3=D). `in_assert` set to 1 sets that port's bit and set to 0 clears it. A repeated message that leaves the bit unchanged produces no upstream message.
- R3: Wire x on downstream port n drives merged wire (x + n) mod 4.
- R4: Each merged wire is the OR over all ports. An upstream message is sent only when a merged wire differs from its last reported level. The message is assert (`out_assert`=1) for a rise and deassert (`out_assert`=0) for a fall, with `out_wire` using the same 0..3 = A..D coding.
- R5: `link_down[n]` clears all four bits of port n, and any resulting merged falls are reported as deasserts. An input message addressed to port n in the same cycle is ignored.
- R6: Differences pending together are sent one per accepted handshake in the order A, B, C, D, regardless of the order in which they arose.
- R7: If a merged wire returns to its last reported level before its change is sent, no message is sent for that wire.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_wire` and `out_assert` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Downstream message present this cycle |
| in_port | input | PORT_W | Downstream port that sent the message |
| in_wire | input | 2 | Wire of the message, 0..3 = A..D |
| in_assert | input | 1 | 1 = assert, 0 = deassert |
| link_down | input | NUM_PORTS | Per-port clear of all four levels |
| out_ready | input | 1 | Upstream accepts the current message |
| out_valid | output | 1 | Upstream message present |
| out_wire | output | 2 | Merged wire of the message, 0..3 = A..D |
| out_assert | output | 1 | 1 = assert, 0 = deassert |

## Verification
The bench targets shared wires held by two ports at once, where a design that forwards messages would send a deassert while another port still holds the level. It also covers the rotation of wire D on the last port, which an off-by-one swizzle would land on the wrong output. Under stall, it raises wire C before wire B and expects B first, which exposes arrival-order emission. It checks that an assert followed by a deassert during a stall leaves no trace, where a queue-based design would send a redundant pair. A link-down that coincides with a message to the same port must not leave that port's bit set.

// File: rtl/intx_pkg.sv
package intx_pkg;
  localparam int WIRES  = 4;
  localparam int WIRE_W = 2;

  typedef logic [WIRES-1:0] wvec_t;

  // Move bit x of a port's local wires to shared position (x + sh) mod WIRES.
  function automatic wvec_t rotate_wires(wvec_t v, int sh);
    wvec_t r;
    for (int x = 0; x < WIRES; x++) begin
      r[(x + sh) % WIRES] = v[x];
    end
    return r;
  endfunction
endpackage

// File: rtl/intx_port_bank.sv
module intx_port_bank
  import intx_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [PORT_W-1:0]    in_port,
  input  logic [WIRE_W-1:0]    in_wire,
  input  logic                 in_assert,
  input  logic [NUM_PORTS-1:0] link_down,
  output wvec_t                merged
);

  logic [NUM_PORTS-1:0][WIRES-1:0] rotated;

  for (genvar n = 0; n < NUM_PORTS; n++) begin : g_port
    wvec_t lvl_q;
    logic  hit;

    assign hit = in_valid && (in_port == PORT_W'(n));

    always_ff @(posedge clk) begin
      if (rst || link_down[n]) begin
        lvl_q <= '0;
      end else if (hit) begin
        lvl_q[in_wire] <= in_assert;
      end
    end

    assign rotated[n] = rotate_wires(lvl_q, n);

    // R5: a link-down leaves the port with no level held
    p_link_clear_r5: assert property (@(posedge clk) disable iff (rst)
      link_down[n] |=> (lvl_q == '0));

    // R2: an accepted message leaves the addressed bit at the message value
    p_level_set_r2: assert property (@(posedge clk) disable iff (rst)
      (hit && !link_down[n]) |=> (lvl_q[$past(in_wire)] == $past(in_assert)));
  end

  always_comb begin
    merged = '0;
    for (int n = 0; n < NUM_PORTS; n++) begin
      merged = merged | rotated[n];
    end
  end

endmodule

// File: rtl/intx_edge_tracker.sv
module intx_edge_tracker
  import intx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  wvec_t             merged,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WIRE_W-1:0] out_wire,
  output logic              out_assert
);

  wvec_t             told_q;
  wvec_t             pend;
  logic [WIRE_W-1:0] pick;
  logic              load;

  // A wire is pending exactly while its level differs from what was reported,
  // so a change that reverts cancels itself.
  assign pend = merged ^ told_q;

  always_comb begin
    pick = '0;
    for (int i = WIRES - 1; i >= 0; i--) begin
      if (pend[i]) pick = WIRE_W'(i);
    end
  end

  assign load = (|pend) && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      told_q     <= '0;
      out_valid  <= 1'b0;
      out_wire   <= '0;
      out_assert <= 1'b0;
    end else if (load) begin
      told_q[pick] <= merged[pick];
      out_valid    <= 1'b1;
      out_wire     <= pick;
      out_assert   <= merged[pick];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8: a stalled message is held unchanged
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_wire) && $stable(out_assert)));

  // R4: any merged level that differs from the reported one yields a message
  p_drain_r4: assert property (@(posedge clk) disable iff (rst)
    (|pend) |=> out_valid);

endmodule

// File: rtl/intx_vw_merge.sv
module intx_vw_merge
  import intx_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [PORT_W-1:0]    in_port,
  input  logic [1:0]           in_wire,
  input  logic                 in_assert,
  input  logic [NUM_PORTS-1:0] link_down,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [1:0]           out_wire,
  output logic                 out_assert
);

  wvec_t merged;

  intx_port_bank #(.NUM_PORTS(NUM_PORTS)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_port   (in_port),
    .in_wire   (in_wire),
    .in_assert (in_assert),
    .link_down (link_down),
    .merged    (merged)
  );

  intx_edge_tracker u_track (
    .clk        (clk),
    .rst        (rst),
    .merged     (merged),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_wire   (out_wire),
    .out_assert (out_assert)
  );

endmodule

// File: tb/intx_vw_merge_test.sv
`timescale 1ns/1ps
module intx_vw_merge_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [1:0] in_port;
  logic [1:0] in_wire;
  logic       in_assert;
  logic [3:0] link_down;
  logic       out_ready;
  logic       out_valid;
  logic [1:0] out_wire;
  logic       out_assert;

  always #4 clk = ~clk;

  intx_vw_merge #(.NUM_PORTS(4)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_port(in_port),
    .in_wire(in_wire), .in_assert(in_assert), .link_down(link_down),
    .out_ready(out_ready), .out_valid(out_valid), .out_wire(out_wire),
    .out_assert(out_assert)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // collected upstream messages (recorded at negedge when a handshake is due)
  logic [1:0] got_w [64];
  logic       got_a [64];
  int         got_n = 0;

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready && got_n < 64) begin
      got_w[got_n] = out_wire;
      got_a[got_n] = out_assert;
      got_n++;
    end
  end

  // {port, wire, assert, expect_msg, exp_wire, exp_assert}
  localparam logic [8:0] VEC [13] = '{
    {2'd0, 2'd0, 1'b1, 1'b1, 2'd0, 1'b1},
    {2'd1, 2'd0, 1'b1, 1'b1, 2'd1, 1'b1},
    {2'd0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0},
    {2'd3, 2'd1, 1'b1, 1'b0, 2'd0, 1'b0},
    {2'd0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0},
    {2'd3, 2'd1, 1'b0, 1'b1, 2'd0, 1'b0},
    {2'd2, 2'd2, 1'b1, 1'b1, 2'd0, 1'b1},
    {2'd1, 2'd3, 1'b1, 1'b0, 2'd0, 1'b0},
    {2'd1, 2'd0, 1'b0, 1'b1, 2'd1, 1'b0},
    {2'd2, 2'd2, 1'b0, 1'b0, 2'd0, 1'b0},
    {2'd1, 2'd3, 1'b0, 1'b1, 2'd0, 1'b0},
    {2'd3, 2'd3, 1'b1, 1'b1, 2'd2, 1'b1},
    {2'd3, 2'd3, 1'b0, 1'b1, 2'd2, 1'b0}
  };

  task automatic check_int(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_msg(string tag, int idx, int ew, int ea);
    check_int({tag, " wire"}, int'(got_w[idx]), ew);
    check_int({tag, " assert"}, int'(got_a[idx]), ea);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic send(int p, int w, int a);
    @(posedge clk); #2;
    in_valid  = 1'b1;
    in_port   = 2'(p);
    in_wire   = 2'(w);
    in_assert = 1'(a);
    @(posedge clk); #2;
    in_valid  = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base;
    rst = 1'b1; in_valid = 1'b0; in_port = '0; in_wire = '0;
    in_assert = 1'b0; link_down = '0; out_ready = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(1);
    check_int("R1 out_valid after reset", int'(out_valid), 0);

    // table walk: R2 R3 R4 with ready held high
    for (int k = 0; k < 13; k++) begin
      base = got_n;
      send(int'(VEC[k][8:7]), int'(VEC[k][6:5]), int'(VEC[k][4]));
      idle(4);
      check_int($sformatf("R2 R3 R4 vector %0d count", k), got_n - base, int'(VEC[k][3]));
      if (VEC[k][3] && got_n > base)
        check_msg($sformatf("R3 R4 vector %0d", k), base, int'(VEC[k][2:1]), int'(VEC[k][0]));
    end

    // R6 R8: stall, C arises before B, expect D then B then C
    base = got_n;
    out_ready = 1'b0;
    send(0, 3, 1);
    send(2, 0, 1);
    send(0, 1, 1);
    idle(1);
    check_int("R8 valid while stalled", int'(out_valid), 1);
    check_int("R8 wire while stalled", int'(out_wire), 3);
    idle(3);
    check_int("R8 wire still held", int'(out_wire), 3);
    check_int("R8 assert still held", int'(out_assert), 1);
    out_ready = 1'b1;
    idle(6);
    check_int("R6 stall drain count", got_n - base, 3);
    check_msg("R6 first", base, 3, 1);
    check_msg("R6 second", base + 1, 1, 1);
    check_msg("R6 third", base + 2, 2, 1);

    // R5 R6: link-down of ports 0 and 2 drops B, C, D together
    base = got_n;
    link_down = 4'b0101;
    idle(1);
    link_down = 4'b0000;
    idle(6);
    check_int("R5 link-down count", got_n - base, 3);
    check_msg("R5 R6 drop B", base, 1, 0);
    check_msg("R5 R6 drop C", base + 1, 2, 0);
    check_msg("R5 R6 drop D", base + 2, 3, 0);

    // R7: an A pulse during stall is cancelled
    base = got_n;
    out_ready = 1'b0;
    send(1, 0, 1);
    send(0, 0, 1);
    send(0, 0, 0);
    idle(1);
    out_ready = 1'b1;
    idle(6);
    check_int("R7 cancelled count", got_n - base, 1);
    check_msg("R7 remaining", base, 1, 1);
    base = got_n;
    send(1, 0, 0);
    idle(4);
    check_int("R7 cleanup count", got_n - base, 1);
    check_msg("R7 cleanup", base, 1, 0);

    // R5: link-down wins over a message to the same port
    base = got_n;
    @(posedge clk); #2;
    link_down = 4'b1000;
    in_valid = 1'b1; in_port = 2'd3; in_wire = 2'd0; in_assert = 1'b1;
    @(posedge clk); #2;
    link_down = 4'b0000; in_valid = 1'b0;
    idle(4);
    check_int("R5 ignored message count", got_n - base, 0);
    send(3, 0, 0);
    idle(4);
    check_int("R5 port stayed clear count", got_n - base, 0);

    // R1: reset in mid-run clears the reported state
    base = got_n;
    send(0, 0, 1);
    idle(4);
    check_int("R1 pre-reset count", got_n - base, 1);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(1);
    check_int("R1 out_valid after second reset", int'(out_valid), 0);
    base = got_n;
    send(0, 0, 1);
    idle(4);
    check_int("R1 re-reported count", got_n - base, 1);
    if (got_n > base) check_msg("R1 re-reported", base, 0, 1);

    finish_run();
  end

endmodule